// File: doc/BRIEF.md
# Overestimating Approximate Adder

An 8-bit ripple-carry adder whose low-order bit positions are built from an increment-capable cell. That cell takes the two operand bits, the incoming carry and one additional unit, and always reports a 2-bit result. A runtime mode pin selects how the block behaves. In exact mode the extra unit carries an optional single increment, so the block returns the true sum. In approximate mode every low cell adds its constant extra unit. Because the cell's result is capped at binary 11, the final sum can come out above the true value but never below it.

The operand conditioning in front of the chain can invert B. Requesting the increment in the same cycle then gives two's complement subtraction. The same increment serves round-half-to-even correction without a second adder pass. The datapath is combinational up to an optional output register. With the default setting the sum and carry-out appear one clock after the inputs are presented, and the mode can change on every cycle. Data moves one operand set per cycle with no handshake: every clock edge accepts the pins as they stand, so there is no back-pressure to manage.

Top module: `overest_adder`

## Requirements
- R1: In exact mode (`approx_en` = 0) the 9-bit value {`cout`,`sum`} equals (A + Beff + `cin` + `plus_one`) mod 512. Beff is `~b` when `inv_b` = 1 and `b` otherwise.
- R2: In approximate mode, ({`cout`,`sum`} − (A + Beff + `cin`)) mod 512 lies between 0 and 2^APX − 1, which is 3 with the default APX = 2.
- R3: In approximate mode, each of bit positions 0 to APX−1 forms t = a_i + beff_i + carry_i + 1 and clamps t to a maximum of 3. The position emits sum bit t mod 2 and carry t div 2, with carry_0 = `cin`. The positions above APX−1 are exact full adders.
- R4: In approximate mode `plus_one` has no effect on `sum` or `cout`.
- R5: With `inv_b` = 1, `plus_one` = 1, `cin` = 0 and exact mode, `sum` = (A − B) mod 256 and `cout` = 1 exactly when A ≥ B.
- R6: With the default output register, the outputs present the result of the inputs sampled at the previous rising edge. The mode takes effect for that operand set only, so alternating the mode on every cycle alternates the result type on every cycle.
- R7: While `rst_n` is low, `sum` and `cout` are 0.
- R8: `cin` and `plus_one` may both be 1 in exact mode and together add 2. For example, A = 255, B = 0 gives {`cout`,`sum`} = 0x101.
- R9: The approximate error reaches its extremes at the low-bit patterns. With all zeros (A = B = 0, `cin` = 0) the result is 3. With the low operand bits all ones and `cin` = 1 (e.g. A = B = 3) the result is exact (7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | 8 | First operand |
| b | input | 8 | Second operand before optional inversion |
| cin | input | 1 | Carry into bit 0 |
| approx_en | input | 1 | 1 selects the approximate overestimating mode |
| plus_one | input | 1 | Single-unit increment request (exact mode) |
| inv_b | input | 1 | 1 inverts B before the addition |
| sum | output | 8 | Sum bits |
| cout | output | 1 | Carry out of bit 7 |

## Verification
On every clock the assertions compare the registered result with an arithmetic reference computed from captured copies of the inputs. They check the exact sum in exact mode, the overestimation window in approximate mode, the subtraction form of the operands, and cleared outputs during reset. Some behaviours can only be shown by the directed scenarios. These are the exact bit pattern produced by the clamped low cells, the fact that `plus_one` is ignored in approximate mode, the one-cycle response to a mode flip, and the specific error extremes. The scenarios sweep every operand pair in approximate mode.

// File: rtl/oa_pkg.sv
package oa_pkg;
  // Carry passed between bit positions. x is a second unit of carry,
  // produced only in exact mode when a position's total reaches four.
  typedef struct packed {
    logic c;
    logic x;
  } carry_pair_t;
endpackage

// File: rtl/oa_pone_cell.sv
module oa_pone_cell
  import oa_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        approx_i,
  input  carry_pair_t ci,
  output logic        s_o,
  output carry_pair_t co
);
  logic [2:0] tot;

  always_comb begin
    tot = {2'b00, a_i} + {2'b00, b_i} + {2'b00, ci.c}
        + (approx_i ? 3'd1 : {2'b00, ci.x});
    if (approx_i) begin
      // total of four is clamped to binary 11
      s_o  = tot[0] | tot[2];
      co.c = tot[1] | tot[2];
      co.x = 1'b0;
    end else begin
      s_o  = tot[0];
      co.c = tot[1] | tot[2];
      co.x = tot[2];
    end
  end
endmodule

// File: rtl/oa_exact_cell.sv
module oa_exact_cell
  import oa_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  carry_pair_t ci,
  output logic        s_o,
  output carry_pair_t co
);
  logic [2:0] tot;

  always_comb begin
    tot  = {2'b00, a_i} + {2'b00, b_i} + {2'b00, ci.c} + {2'b00, ci.x};
    s_o  = tot[0];
    co.c = tot[1] | tot[2];
    co.x = tot[2];
  end
endmodule

// File: rtl/oa_chain.sv
module oa_chain
  import oa_pkg::*;
#(
  parameter int W   = 8,
  parameter int APX = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         approx_i,
  input  carry_pair_t  head_i,
  output logic [W-1:0] s_o,
  output carry_pair_t  tail_o
);
  carry_pair_t link [0:W];

  assign link[0] = head_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < APX) begin : g_low
      oa_pone_cell u_cell (
        .a_i      (a_i[i]),
        .b_i      (b_i[i]),
        .approx_i (approx_i),
        .ci       (link[i]),
        .s_o      (s_o[i]),
        .co       (link[i+1])
      );
    end else begin : g_high
      oa_exact_cell u_cell (
        .a_i (a_i[i]),
        .b_i (b_i[i]),
        .ci  (link[i]),
        .s_o (s_o[i]),
        .co  (link[i+1])
      );
    end
  end

  assign tail_o = link[W];
endmodule

// File: rtl/overest_adder.sv
module overest_adder
  import oa_pkg::*;
#(
  parameter int W       = 8,
  parameter int APX     = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         approx_en,
  input  logic         plus_one,
  input  logic         inv_b,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int RW      = W + 1;
  localparam int ERR_MAX = (1 << APX) - 1;

  logic [W-1:0] b_eff;
  carry_pair_t  head;
  carry_pair_t  tail;
  logic [W-1:0] sum_c;
  logic         cout_c;

  assign b_eff  = inv_b ? ~b : b;
  assign head.c = cin;
  assign head.x = plus_one & ~approx_en;

  oa_chain #(.W(W), .APX(APX)) u_chain (
    .a_i      (a),
    .b_i      (b_eff),
    .approx_i (approx_en),
    .head_i   (head),
    .s_o      (sum_c),
    .tail_o   (tail)
  );

  // the doubled carry at the top is worth two, so bit W sees only its parity
  assign cout_c = tail.c ^ tail.x;

  if (REG_OUT) begin : g_reg
    logic [W-1:0] sum_q;
    logic         cout_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
      end else begin
        sum_q  <= sum_c;
        cout_q <= cout_c;
      end
    end

    assign sum  = sum_q;
    assign cout = cout_q;

    // captured operands for the checks below
    logic [W-1:0] a_q, b_q, be_q;
    logic         cin_q, p_q, ap_q, inv_q, armed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0; b_q <= '0; be_q <= '0;
        cin_q <= 1'b0; p_q <= 1'b0; ap_q <= 1'b0; inv_q <= 1'b0;
        armed <= 1'b0;
      end else begin
        a_q <= a; b_q <= b; be_q <= (inv_b ? ~b : b);
        cin_q <= cin; p_q <= plus_one; ap_q <= approx_en; inv_q <= inv_b;
        armed <= 1'b1;
      end
    end

    AST_EXACT_MODE: assert property (@(posedge clk) disable iff (!rst_n) (armed && !ap_q) |-> ({cout, sum} == RW'(RW'(a_q) + RW'(be_q) + RW'(cin_q) + RW'(p_q)))); // R1
    AST_OVER_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (armed && ap_q) |-> (RW'({cout, sum} - RW'(RW'(a_q) + RW'(be_q) + RW'(cin_q))) <= RW'(ERR_MAX))); // R2
    AST_SUBTRACT: assert property (@(posedge clk) disable iff (!rst_n) (armed && !ap_q && inv_q && p_q && !cin_q) |-> ((sum == W'(a_q - b_q)) && (cout == (a_q >= b_q)))); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> ((sum == '0) && !cout)); // R7
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = cout_c;
  end
endmodule

// File: tb/overest_adder_tb.sv
module overest_adder_tb;
  localparam int W   = 8;
  localparam int APX = 2;
  localparam int EMX = (1 << APX) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0, approx_en = 1'b0, plus_one = 1'b0, inv_b = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int n_chk = 0;
  int n_bad = 0;

  logic [W:0] pend_exp, pend_base;
  logic       pend = 1'b0, pend_bnd = 1'b0;
  string      pend_tag;

  always #2 clk = ~clk;

  overest_adder #(.W(W), .APX(APX), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
    .approx_en(approx_en), .plus_one(plus_one), .inv_b(inv_b),
    .sum(sum), .cout(cout)
  );

  function automatic logic [W:0] m_exact(logic [W-1:0] x, logic [W-1:0] y, logic c, logic p);
    return (W+1)'(x) + (W+1)'(y) + (W+1)'(c) + (W+1)'(p);
  endfunction

  // model of the approximate chain taken from R3
  function automatic logic [W:0] m_approx(logic [W-1:0] x, logic [W-1:0] y, logic c);
    logic [W:0] r;
    int cy, t;
    cy = int'(c);
    r = '0;
    for (int i = 0; i < W; i++) begin
      t = int'(x[i]) + int'(y[i]) + cy + ((i < APX) ? 1 : 0);
      if (i < APX && t > 3) t = 3;
      r[i] = t[0];
      cy = t / 2;
    end
    r[W] = cy[0];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    logic [W:0] got, dif;
    if (pend) begin
      got = {cout, sum};
      chk(pend_tag, got, pend_exp);
      if (pend_bnd) begin
        n_chk++;
        dif = got - pend_base;
        if ($isunknown(got) || dif > (W+1)'(EMX)) begin
          n_bad++;
          $display("FAIL R2: got %h expected within %h..%h", got, pend_base, pend_base + (W+1)'(EMX));
        end
      end
    end
  endtask

  task automatic push(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic ic,
                      input logic iap, input logic ip, input logic iinv,
                      input logic [W:0] exp, input logic bnd, input string tag);
    @(negedge clk);
    settle();
    a = ia; b = ib; cin = ic; approx_en = iap; plus_one = ip; inv_b = iinv;
    pend = 1'b1; pend_exp = exp; pend_bnd = bnd; pend_tag = tag;
    pend_base = m_exact(ia, iinv ? ~ib : ib, ic, 1'b0);
  endtask

  task automatic flush();
    @(negedge clk);
    settle();
    pend = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    a = 8'hFF; b = 8'hFF; cin = 1'b1; plus_one = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 reset", {cout, sum}, 9'h000);
    @(negedge clk);
    chk("R7 reset held", {cout, sum}, 9'h000);
    rst_n = 1'b1;
  endtask

  task automatic t_exact();
    for (int x = 0; x < 256; x += 5)
      for (int y = 0; y < 256; y += 11)
        for (int k = 0; k < 4; k++)
          push(8'(x), 8'(y), k[0], 1'b0, k[1], x[0] ^ y[1],
               m_exact(8'(x), (x[0] ^ y[1]) ? ~8'(y) : 8'(y), k[0], k[1]), 1'b0, "R1 exact");
    flush();
  endtask

  task automatic t_double_carry();
    push(8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 9'h101, 1'b0, "R8 cin+inc");
    push(8'h01, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 9'h004, 1'b0, "R8 cin+inc low");
    push(8'hFE, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 9'h101, 1'b0, "R8 cin+inc wrap");
    flush();
  endtask

  task automatic t_subtract();
    for (int x = 0; x < 256; x += 3)
      for (int y = 0; y < 256; y += 17)
        push(8'(x), 8'(y), 1'b0, 1'b0, 1'b1, 1'b1,
             {(x >= y) ? 1'b1 : 1'b0, 8'(x - y)}, 1'b0, "R5 subtract");
    flush();
  endtask

  task automatic t_approx_all();
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        push(8'(x), 8'(y), x[3] ^ y[0], 1'b1, 1'b0, x[5],
             m_approx(8'(x), x[5] ? ~8'(y) : 8'(y), x[3] ^ y[0]), 1'b1, "R3 approx");
    flush();
  endtask

  task automatic t_inc_ignored();
    for (int x = 0; x < 256; x += 7)
      for (int y = 0; y < 256; y += 13)
        push(8'(x), 8'(y), y[2], 1'b1, 1'b1, 1'b0,
             m_approx(8'(x), 8'(y), y[2]), 1'b0, "R4 plus_one ignored");
    flush();
  endtask

  task automatic t_mode_flip();
    for (int n = 0; n < 8; n++) begin
      push(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 9'h003, 1'b0, "R6 flip approx");
      push(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, "R6 flip exact");
    end
    flush();
  endtask

  task automatic t_extremes();
    push(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 9'h003, 1'b0, "R9 max error");
    push(8'h03, 8'h03, 1'b1, 1'b1, 1'b0, 1'b0, 9'h007, 1'b0, "R9 zero error");
    push(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 9'h1FF, 1'b0, "R9 all ones");
    push(8'hFC, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 9'h0FF, 1'b0, "R9 no wrap");
    flush();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_exact();
    t_double_carry();
    t_subtract();
    t_approx_all();
    t_inc_ignored();
    t_mode_flip();
    t_extremes();
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    report();
    $finish;
  end
endmodule